// File: doc/BRIEF.md
# Split-Period PWM Generator

This block produces a pulse-width modulated output whose high time and low time are two independent clock-cycle counts rather than a period plus a compare threshold. A command sequencer loads the two counts over a shared data bus using two separate write strobes, one for the high count and one for the low count.

The high count written through its strobe is only staged. It has no effect on the waveform already running. The low-count strobe commits the staged high count and the new low count together, and it restarts the waveform from the start of a high phase. The intended sequence is therefore: write the high count first, then the low count.

A one-cycle marker pulse can be enabled by a parameter. It flags the first cycle of every high phase. Degenerate count pairs hold the output at a fixed level.

Top module: `split_pwm`

## Requirements
- R1: After reset, with the default reset counts of zero, `pwm_out` and `cycle_start` are both 0.
- R2: With committed high count H>0 and low count L>0 (each a 16-bit count of clock cycles), `pwm_out` is 1 for exactly H cycles and then 0 for L cycles. This repeats with a period of H+L cycles.
- R3: Pulsing `on_wr` alone stores `wr_data` as the staged high count and leaves `pwm_out` and `cycle_start` unchanged.
- R4: A cycle in which `off_wr` is sampled high commits `wr_data` as the low count and the staged value as the high count. The cycle that follows is the first cycle of a fresh high phase under the new counts.
- R5: Pulsing `off_wr` without a new `on_wr` reuses the high count staged earlier.
- R6: A committed high count of 0 holds `pwm_out` at 0.
- R7: A committed low count of 0 with a nonzero high count holds `pwm_out` at 1.
- R8: When both committed counts are 0, `pwm_out` is held at 0.
- R9: `cycle_start` is a one-cycle pulse in the first cycle of each high phase. It is raised together with that cycle's `pwm_out`, and it does not repeat while the output is held high.
- R10: The minimum counts H=1, L=1 give an output that toggles every cycle, and counts of several hundred cycles are timed exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| on_wr | input | 1 | Stage `wr_data` as the next high count |
| off_wr | input | 1 | Commit `wr_data` as the low count and restart |
| wr_data | input | 16 | Count value for either strobe |
| pwm_out | output | 1 | PWM waveform |
| cycle_start | output | 1 | Pulse in the first cycle of each high phase |

## Verification
The bound checker watches several properties on every cycle:
- the level right after a restart, which must match the staged high count;
- a zero high count forcing a low output;
- a zero low count keeping the output high;
- the marker pulse coinciding with a high output and every non-restart rising edge;
- committed counts staying put while no low-count write occurs.

Only the bench scenarios can show the exact length of each phase and the period across many repeats. They also show that a mid-waveform high-count write leaves the timing intact, and that an off-only write reuses the earlier staged value.

// File: rtl/split_pwm_pkg.sv
package split_pwm_pkg;
   typedef enum logic {PH_LO = 1'b0, PH_HI = 1'b1} phase_e;
endpackage

// File: rtl/split_pwm_regs.sv
module split_pwm_regs #(
   parameter int CNT_W  = 16,
   parameter int DEF_ON = 0,
   parameter int DEF_OFF = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             on_wr,
   input  logic             off_wr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] stage_on,
   output logic [CNT_W-1:0] act_on,
   output logic [CNT_W-1:0] act_off
);
   localparam logic [CNT_W-1:0] RST_ON  = CNT_W'(DEF_ON);
   localparam logic [CNT_W-1:0] RST_OFF = CNT_W'(DEF_OFF);

   // staging register: written by the high-count strobe only
   always_ff @(posedge clk) begin
      if (!rst_n)     stage_on <= RST_ON;
      else if (on_wr) stage_on <= wr_data;
   end

   // committed pair: loaded together by the low-count strobe
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_on  <= RST_ON;
         act_off <= RST_OFF;
      end else if (off_wr) begin
         act_on  <= stage_on;
         act_off <= wr_data;
      end
   end
endmodule

// File: rtl/split_pwm_engine.sv
module split_pwm_engine
   import split_pwm_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DEF_ON = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] new_on,
   input  logic [CNT_W-1:0] act_on,
   input  logic [CNT_W-1:0] act_off,
   output logic             level,
   output logic             start_q
);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO    = '0;
   localparam bit               RST_HI  = (DEF_ON != 0);

   phase_e           phase;
   logic [CNT_W-1:0] cnt;
   logic             hi_done, lo_done;

   assign hi_done = (cnt == act_on - ONE);
   assign lo_done = (act_off == ZERO) || (cnt == act_off - ONE);
   assign level   = (phase == PH_HI);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= RST_HI ? PH_HI : PH_LO;
         cnt     <= ZERO;
         start_q <= RST_HI;
      end else if (restart) begin
         phase   <= (new_on != ZERO) ? PH_HI : PH_LO;
         cnt     <= ZERO;
         start_q <= (new_on != ZERO);
      end else begin
         start_q <= 1'b0;
         unique case (phase)
            PH_HI: begin
               if (hi_done) begin
                  cnt <= ZERO;
                  if (act_off != ZERO) phase <= PH_LO;
               end else begin
                  cnt <= cnt + ONE;
               end
            end
            PH_LO: begin
               if (lo_done) begin
                  cnt <= ZERO;
                  if (act_on != ZERO) begin
                     phase   <= PH_HI;
                     start_q <= 1'b1;
                  end
               end else begin
                  cnt <= cnt + ONE;
               end
            end
            default: phase <= PH_LO;
         endcase
      end
   end
endmodule

// File: rtl/split_pwm.sv
module split_pwm #(
   parameter int CNT_W      = 16,
   parameter int DEF_ON     = 0,
   parameter int DEF_OFF    = 0,
   parameter bit EMIT_START = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             on_wr,
   input  logic             off_wr,
   input  logic [CNT_W-1:0] wr_data,
   output logic             pwm_out,
   output logic             cycle_start
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("split_pwm: CNT_W must lie in 2..32");
   end
   if (DEF_ON < 0 || DEF_ON >= (64'd1 << CNT_W) || DEF_OFF < 0 || DEF_OFF >= (64'd1 << CNT_W)) begin : g_bad_default
      $error("split_pwm: reset counts must fit in CNT_W bits");
   end

   logic [CNT_W-1:0] stage_on, act_on, act_off;
   logic             start_q;

   split_pwm_regs #(.CNT_W(CNT_W), .DEF_ON(DEF_ON), .DEF_OFF(DEF_OFF)) u_regs (
      .clk(clk), .rst_n(rst_n), .on_wr(on_wr), .off_wr(off_wr), .wr_data(wr_data),
      .stage_on(stage_on), .act_on(act_on), .act_off(act_off)
   );

   split_pwm_engine #(.CNT_W(CNT_W), .DEF_ON(DEF_ON)) u_engine (
      .clk(clk), .rst_n(rst_n), .restart(off_wr), .new_on(stage_on),
      .act_on(act_on), .act_off(act_off), .level(pwm_out), .start_q(start_q)
   );

   if (EMIT_START) begin : g_start
      assign cycle_start = start_q;
   end else begin : g_no_start
      assign cycle_start = 1'b0;
   end
endmodule

// File: rtl/split_pwm_chk.sv
module split_pwm_chk #(
   parameter int CNT_W      = 16,
   parameter bit EMIT_START = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             on_wr,
   input logic             off_wr,
   input logic [CNT_W-1:0] stage_on,
   input logic [CNT_W-1:0] act_on,
   input logic [CNT_W-1:0] act_off,
   input logic             pwm_out,
   input logic             cycle_start
);
   // R4
   restart_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      off_wr |=> (pwm_out == ($past(stage_on) != '0)));
   // R6
   zero_high_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_on == '0) |-> !pwm_out);
   // R7
   zero_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_out && act_off == '0 && !off_wr) |=> pwm_out);
   // R3
   stage_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !off_wr |=> ($stable(act_on) && $stable(act_off)));
   // R9
   start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_start |-> pwm_out);
   // R9
   start_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (EMIT_START && pwm_out && !$past(pwm_out)) |-> cycle_start);
   // R9
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cycle_start && !off_wr) |=> !cycle_start);
endmodule

bind split_pwm split_pwm_chk #(.CNT_W(CNT_W), .EMIT_START(EMIT_START)) u_chk (
   .clk(clk), .rst_n(rst_n), .on_wr(on_wr), .off_wr(off_wr),
   .stage_on(stage_on), .act_on(act_on), .act_off(act_off),
   .pwm_out(pwm_out), .cycle_start(cycle_start)
);

// File: tb/split_pwm_tb.sv
module split_pwm_tb;
   typedef struct {
      bit    lvl;
      bit    st;
      string req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        on_wr = 1'b0;
   logic        off_wr = 1'b0;
   logic [15:0] wr_data = '0;
   logic        pwm_out, cycle_start;

   int   checks = 0;
   int   errors = 0;
   exp_t exp_q[$];

   always #10 clk = ~clk;

   split_pwm u_dut (
      .clk(clk), .rst_n(rst_n), .on_wr(on_wr), .off_wr(off_wr),
      .wr_data(wr_data), .pwm_out(pwm_out), .cycle_start(cycle_start)
   );

   task automatic push_expect(input int h, input int l, input int n, input string req);
      for (int i = 0; i < n; i++) begin
         exp_t e;
         int pos;
         pos   = (h + l) > 0 ? i % (h + l) : 0;
         e.lvl = (h > 0) && (l == 0 || pos < h);
         e.st  = (h > 0) && ((l == 0) ? (i == 0) : (pos == 0));
         e.req = req;
         exp_q.push_back(e);
      end
   endtask

   task automatic write_on(input int v);
      on_wr   = 1'b1;
      wr_data = 16'(v);
      @(negedge clk);
      on_wr   = 1'b0;
   endtask

   task automatic write_off(input int v, input int staged, input int n, input string req);
      off_wr  = 1'b1;
      wr_data = 16'(v);
      @(posedge clk);
      push_expect(staged, v, n, req);
      @(negedge clk);
      off_wr  = 1'b0;
   endtask

   task automatic drain;
      while (exp_q.size() > 0) @(negedge clk);
      @(negedge clk);
   endtask

   // monitor: pops expectations on each falling edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         checks++;
         if (pwm_out !== e.lvl || cycle_start !== e.st) begin
            errors++;
            $display("FAIL %s: pwm_out=%0b cycle_start=%0b expected %0b/%0b",
                     e.req, pwm_out, cycle_start, e.lvl, e.st);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: idle after reset
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         checks++;
         if (pwm_out !== 1'b0 || cycle_start !== 1'b0) begin
            errors++;
            $display("FAIL R1: pwm_out=%0b cycle_start=%0b expected 0/0", pwm_out, cycle_start);
         end
      end
      // R2, R4, R9: basic waveform, then R3: staging mid-run
      write_on(5);
      write_off(3, 5, 30, "R2");
      repeat (6) @(negedge clk);
      write_on(2);
      drain();
      // R4: restart takes staged 2 with low 4
      write_off(4, 2, 20, "R4");
      drain();
      // R5: off-only write reuses the staged 2
      write_off(6, 2, 24, "R5");
      drain();
      // R6: zero high count
      write_on(0);
      write_off(7, 0, 16, "R6");
      drain();
      // R7: zero low count holds high, single start pulse (R9)
      write_on(3);
      write_off(0, 3, 14, "R7");
      drain();
      // R8: both zero
      write_on(0);
      write_off(0, 0, 10, "R8");
      drain();
      // R10: minimum counts, then long counts
      write_on(1);
      write_off(1, 1, 12, "R10");
      drain();
      write_on(300);
      write_off(2, 300, 610, "R10");
      drain();
      // R9: rising edges mark starts again after hold-high
      write_on(2);
      write_off(5, 2, 21, "R9");
      drain();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule